// File: doc/BRIEF.md
# Chip Select Decoder with Spare Window

This block turns a 20-bit address and a memory/IO qualifier into active-low chip selects for a small memory system. A 64KB main device fills 70000H–7FFFFH. A 512-byte spare device claims a window that covers a damaged stretch of the main device (local offsets 3210H–3317H). Inside that window the spare device answers in place of the main one. A second decoder drives four 8KB bank selects from base 30000H through a 2-to-4 decode. A parameter can drop upper address bits from the bank comparison, which gives partial decoding with aliases.

Each device receives its local address as a plain slice of the bus address. A flag reports memory cycles that no device claims, and a constant output reports whether the bank decode is partial. An optional output register stage, with a synchronous active-high reset, delays all outputs by one clock.

Top module: `chip_sel_remap`

## Requirements
- R1: `main_cs_n` is low exactly when `mem_sel`=1, A[19:16]=0111, and the address lies outside the spare window.
- R2: `spare_cs_n` is low exactly when `mem_sel`=1 and A[19:9] equals 73200H>>9, which is the window 73200H–733FFH. This window covers the damaged range 73210H–73317H.
- R3: At most one chip select is low in any cycle, and the main select is high whenever the spare select is low.
- R4: With full bank decoding, `bank_cs_n[k]` is low exactly when `mem_sel`=1, A[19:15]=00110 and k=A[14:13]. All other bank bits stay high.
- R5: When `mem_sel`=0 (I/O cycle), every chip select is high and `unmapped` is low.
- R6: `unmapped` is high exactly when `mem_sel`=1 and no chip select is low.
- R7: `main_addr`=A[15:0], `spare_addr`=A[8:0] and `bank_addr`=A[12:0], passed through unchanged.
- R8: With `BANK_CMP_W` below 5, only the lowest `BANK_CMP_W` bits of A[19:15] are compared, so aliased addresses such as 02117H and 9A117H select bank A[14:13]. `partial_decode` is 1 in this case and 0 under full decoding.
- R9: A bank alias never overrides the main or spare device. Inside 70000H–7FFFFH the bank selects stay high.
- R10: With `REG_OUT`=1, the outputs show the decode of the inputs sampled at the previous rising edge. Reset drives the selects high, `unmapped` low and the local addresses to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 20 | Bus address |
| mem_sel | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| main_cs_n | output | 1 | Main device select, active low |
| spare_cs_n | output | 1 | Spare device select, active low |
| bank_cs_n | output | 4 | Bank selects, active low, index A[14:13] |
| main_addr | output | 16 | Main device local address |
| spare_addr | output | 9 | Spare device local address |
| bank_addr | output | 13 | Bank local address |
| unmapped | output | 1 | Memory cycle claimed by no device |
| partial_decode | output | 1 | 1 when the bank decode ignores upper bits |

## Verification
Every address from 73200H to 733FFH hits both the main range and the spare window in the same cycle. A sweep runs through that window and its edges (731FFH, 73400H). It passes only if the spare select alone goes low. A second instance with an open bank compare makes bank aliases coincide with the main range over 70000H–7FFFFH, and there only the main or spare select may be seen.

// File: rtl/csd_pkg.sv
`timescale 1ns/1ps
package csd_pkg;

    // Which device owns the current address
    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_SPARE = 2'd1,
        OWN_MAIN  = 2'd2,
        OWN_BANK  = 2'd3
    } owner_e;

    // Spare window first, then main range, then banks
    function automatic owner_e pick_owner(input logic is_mem,
                                          input logic spare_win,
                                          input logic main_win,
                                          input logic bank_win);
        if (!is_mem)        return OWN_NONE;
        else if (spare_win) return OWN_SPARE;
        else if (main_win)  return OWN_MAIN;
        else if (bank_win)  return OWN_BANK;
        else                return OWN_NONE;
    endfunction

endpackage

// File: rtl/csd_window_match.sv
`timescale 1ns/1ps
module csd_window_match #(
    parameter int FIELD_W = 4,
    parameter int CMP_W   = 4,
    parameter logic [FIELD_W-1:0] BASE_FIELD = '0
) (
    input  logic [FIELD_W-1:0] field,
    output logic               hit
);
    generate
        if (CMP_W == 0) begin : g_open
            assign hit = 1'b1;
        end else begin : g_cmp
            assign hit = (field[CMP_W-1:0] == BASE_FIELD[CMP_W-1:0]);
        end
    endgenerate
endmodule

// File: rtl/csd_onehot_dec.sv
`timescale 1ns/1ps
module csd_onehot_dec #(
    parameter int SEL_W = 2,
    localparam int N    = 1 << SEL_W
) (
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    output logic [N-1:0]     sel_n
);
    generate
        for (genvar k = 0; k < N; k++) begin : g_line
            assign sel_n[k] = ~(en && (sel == SEL_W'(k)));
        end
    endgenerate
endmodule

// File: rtl/csd_out_stage.sv
`timescale 1ns/1ps
module csd_out_stage #(
    parameter int W = 8,
    parameter bit REG = 1'b1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (REG) begin : g_reg
            logic armed;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q     <= RST_VAL;
                    armed <= 1'b0;
                end else begin
                    q     <= d;
                    armed <= 1'b1;
                end
            end

            assert_stage_delay_R10: assert property (@(posedge clk) disable iff (rst)
                armed |-> (q == $past(d)))
                else $error("output stage lost a cycle");
        end else begin : g_wire
            assign q = d;
        end
    endgenerate
endmodule

// File: rtl/chip_sel_remap.sv
`timescale 1ns/1ps
module chip_sel_remap
    import csd_pkg::*;
#(
    parameter int ADDR_W      = 20,
    parameter int MAIN_AW     = 16,
    parameter logic [ADDR_W-1:0] MAIN_BASE  = 20'h70000,
    parameter int SPARE_AW    = 9,
    parameter logic [ADDR_W-1:0] SPARE_BASE = 20'h73200,
    parameter int BANK_AW     = 13,
    parameter int BANK_SEL_W  = 2,
    parameter logic [ADDR_W-1:0] BANK_BASE  = 20'h30000,
    parameter int BANK_CMP_W  = ADDR_W - BANK_AW - BANK_SEL_W,
    parameter bit REG_OUT     = 1'b1,
    localparam int BANK_N     = 1 << BANK_SEL_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                mem_sel,
    output logic                main_cs_n,
    output logic                spare_cs_n,
    output logic [BANK_N-1:0]   bank_cs_n,
    output logic [MAIN_AW-1:0]  main_addr,
    output logic [SPARE_AW-1:0] spare_addr,
    output logic [BANK_AW-1:0]  bank_addr,
    output logic                unmapped,
    output logic                partial_decode
);
    localparam int MAIN_FW  = ADDR_W - MAIN_AW;
    localparam int SPARE_FW = ADDR_W - SPARE_AW;
    localparam int BANK_LO  = BANK_AW + BANK_SEL_W;
    localparam int BANK_FW  = ADDR_W - BANK_LO;
    localparam bit PARTIAL  = (BANK_CMP_W < BANK_FW);
    localparam int OUT_W    = 3 + BANK_N + MAIN_AW + SPARE_AW + BANK_AW;
    localparam logic [OUT_W-1:0] OUT_RST =
        {1'b1, 1'b1, {BANK_N{1'b1}}, 1'b0, {(MAIN_AW + SPARE_AW + BANK_AW){1'b0}}};

    logic main_win, spare_win, bank_win;
    owner_e owner;
    logic main_n_c, spare_n_c, unmapped_c;
    logic [BANK_N-1:0] bank_n_c;
    logic [OUT_W-1:0] pack_d, pack_q;

    csd_window_match #(
        .FIELD_W(MAIN_FW), .CMP_W(MAIN_FW),
        .BASE_FIELD(MAIN_BASE[ADDR_W-1:MAIN_AW])
    ) u_main_win (
        .field(addr[ADDR_W-1:MAIN_AW]), .hit(main_win)
    );

    csd_window_match #(
        .FIELD_W(SPARE_FW), .CMP_W(SPARE_FW),
        .BASE_FIELD(SPARE_BASE[ADDR_W-1:SPARE_AW])
    ) u_spare_win (
        .field(addr[ADDR_W-1:SPARE_AW]), .hit(spare_win)
    );

    csd_window_match #(
        .FIELD_W(BANK_FW), .CMP_W(BANK_CMP_W),
        .BASE_FIELD(BANK_BASE[ADDR_W-1:BANK_LO])
    ) u_bank_win (
        .field(addr[ADDR_W-1:BANK_LO]), .hit(bank_win)
    );

    always_comb begin
        owner      = pick_owner(mem_sel, spare_win, main_win, bank_win);
        main_n_c   = (owner != OWN_MAIN);
        spare_n_c  = (owner != OWN_SPARE);
        unmapped_c = mem_sel && (owner == OWN_NONE);
    end

    csd_onehot_dec #(.SEL_W(BANK_SEL_W)) u_bank_dec (
        .en(owner == OWN_BANK),
        .sel(addr[BANK_LO-1:BANK_AW]),
        .sel_n(bank_n_c)
    );

    assign pack_d = {main_n_c, spare_n_c, bank_n_c, unmapped_c,
                     addr[MAIN_AW-1:0], addr[SPARE_AW-1:0], addr[BANK_AW-1:0]};

    csd_out_stage #(.W(OUT_W), .REG(REG_OUT), .RST_VAL(OUT_RST)) u_out (
        .clk(clk), .rst(rst), .d(pack_d), .q(pack_q)
    );

    assign {main_cs_n, spare_cs_n, bank_cs_n, unmapped,
            main_addr, spare_addr, bank_addr} = pack_q;
    assign partial_decode = PARTIAL;

    assert_io_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        !mem_sel |-> (main_n_c && spare_n_c && (&bank_n_c) && !unmapped_c))
        else $error("select active in I/O cycle");

    assert_single_owner_R3: assert property (@(posedge clk) disable iff (rst)
        $countones({~main_n_c, ~spare_n_c, ~bank_n_c}) <= 1)
        else $error("more than one device selected");

    assert_spare_blocks_main_R3: assert property (@(posedge clk) disable iff (rst)
        !spare_n_c |-> main_n_c)
        else $error("main selected inside spare window");

    assert_unmapped_idle_R6: assert property (@(posedge clk) disable iff (rst)
        unmapped_c |-> (mem_sel && main_n_c && spare_n_c && (&bank_n_c)))
        else $error("unmapped flagged while a device is selected");

    assert_bank_onehot_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~bank_n_c))
        else $error("bank decode not one-hot");

    assert_alias_yields_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_sel && main_win) |-> (&bank_n_c))
        else $error("bank alias overrode main range");
endmodule

// File: tb/sim_chip_sel_remap.sv
`timescale 1ns/1ps
module sim_chip_sel_remap;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [19:0] addr_i = '0;
    logic mem_i = 1'b0;
    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    logic m0_n, s0_n, u0_un, p0;
    logic [3:0] b0_n;
    logic [15:0] ma0; logic [8:0] sa0; logic [12:0] ba0;
    logic m1_n, s1_n, u1_un, p1;
    logic [3:0] b1_n;
    logic [15:0] ma1; logic [8:0] sa1; logic [12:0] ba1;

    chip_sel_remap u0 (
        .clk(clk), .rst(rst), .addr(addr_i), .mem_sel(mem_i),
        .main_cs_n(m0_n), .spare_cs_n(s0_n), .bank_cs_n(b0_n),
        .main_addr(ma0), .spare_addr(sa0), .bank_addr(ba0),
        .unmapped(u0_un), .partial_decode(p0)
    );

    chip_sel_remap #(.BANK_CMP_W(0), .REG_OUT(1'b0)) u1 (
        .clk(clk), .rst(rst), .addr(addr_i), .mem_sel(mem_i),
        .main_cs_n(m1_n), .spare_cs_n(s1_n), .bank_cs_n(b1_n),
        .main_addr(ma1), .spare_addr(sa1), .bank_addr(ba1),
        .unmapped(u1_un), .partial_decode(p1)
    );

    task automatic chk(input string tag, input logic [19:0] act, input logic [19:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s addr=%05h actual=%0h expected=%0h", tag, addr_i, act, exp);
        end
    endtask

    task automatic check_all(input logic [19:0] a, input logic m);
        logic sp, mn, bk, un, in_main, bk1, un1;
        logic [3:0] bexp, bexp1;
        int idx;
        sp = m && (a >= 20'h73200) && (a <= 20'h733FF);
        in_main = (a >= 20'h70000) && (a <= 20'h7FFFF);
        mn = m && in_main && !sp;
        bk = m && (a >= 20'h30000) && (a <= 20'h37FFF);
        idx = int'((a >> 13) & 20'h3);
        bexp = 4'hF; if (bk) bexp[idx] = 1'b0;
        un = m && !(sp || mn || bk);
        // full-decode instance (registered)
        chk("R1 main", 20'(m0_n), 20'(!mn));
        chk("R2 spare", 20'(s0_n), 20'(!sp));
        chk("R4 bank", 20'(b0_n), 20'(bexp));
        chk(m ? "R6 unmapped" : "R5 io unmapped", 20'(u0_un), 20'(un));
        chk("R3 count", 20'((!m0_n) + (!s0_n) + (4 - $countones(b0_n))), 20'(m && (sp || mn || bk)));
        chk("R7 main_addr", 20'(ma0), a & 20'hFFFF);
        chk("R7 spare_addr", 20'(sa0), a & 20'h1FF);
        chk("R7 bank_addr", 20'(ba0), a & 20'h1FFF);
        chk("R8 full flag", 20'(p0), 20'd0);
        // partial-decode instance (combinational)
        bk1 = m && !sp && !in_main;
        bexp1 = 4'hF; if (bk1) bexp1[idx] = 1'b0;
        un1 = m && !(sp || mn || bk1);
        chk("R2 spare u1", 20'(s1_n), 20'(!sp));
        chk("R1 main u1", 20'(m1_n), 20'(!mn));
        chk(in_main ? "R9 alias yields" : "R8 alias bank", 20'(b1_n), 20'(bexp1));
        chk(m ? "R6 unmapped u1" : "R5 io u1", 20'(u1_un), 20'(un1));
        chk("R8 partial flag", 20'(p1), 20'd1);
    endtask

    task automatic apply(input logic [19:0] a, input logic m);
        addr_i = a;
        mem_i = m;
        @(negedge clk);
        check_all(a, m);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    localparam logic [19:0] EDGES [16] = '{
        20'h731FF, 20'h73200, 20'h73210, 20'h73317, 20'h733FF, 20'h73400,
        20'h6FFFF, 20'h70000, 20'h7FFFF, 20'h80000, 20'h2FFFF, 20'h30000,
        20'h37FFF, 20'h38000, 20'h02117, 20'h9A117
    };

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 reset main", 20'(m0_n), 20'd1);
        chk("R10 reset spare", 20'(s0_n), 20'd1);
        chk("R10 reset bank", 20'(b0_n), 20'hF);
        chk("R10 reset unmapped", 20'(u0_un), 20'd0);
        chk("R10 reset addr", 20'(ma0), 20'd0);
        rst = 1'b0;
        apply(20'h70010, 1'b1);
        // R10 latency: new address not visible before the next edge
        addr_i = 20'h73250;
        #1;
        chk("R10 hold main", 20'(m0_n), 20'd0);
        chk("R10 hold spare", 20'(s0_n), 20'd1);
        @(negedge clk);
        check_all(20'h73250, 1'b1);
        // R8 aliases seen combinationally on u1
        apply(20'h02117, 1'b1);
        chk("R8 alias 02117", 20'(b1_n), 20'hD);
        apply(20'h9A117, 1'b1);
        chk("R8 alias 9A117", 20'(b1_n), 20'hD);
        for (int e = 0; e < 16; e++) begin
            apply(EDGES[e], 1'b1);
            apply(EDGES[e], 1'b0);
        end
        for (int i = 0; i < 65536; i++)
            apply({i[15:0], 4'(i ^ (i >> 4))}, 1'b1);
        for (int i = 0; i < 4096; i++)
            apply({i[11:0], 8'(i * 37)}, 1'b0);
        // R10 reset mid-run
        rst = 1'b1;
        @(negedge clk);
        chk("R10 rerun reset main", 20'(m0_n), 20'd1);
        chk("R10 rerun reset bank_addr", 20'(ba0), 20'd0);
        rst = 1'b0;
        apply(20'h36001, 1'b1);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule